// File: doc/BRIEF.md
# Slew-Rate Calibration Sequencer

This block measures a free-running clock and turns the result into a 3-bit slew-rate trim code for a high-speed transmitter. A single-cycle `start` pulse begins the run. The block raises a calibration enable and waits one settle interval. It then turns on the free-running clock gate, loads the measurement window register with 0x400 reference cycles, and enables a small counting frequency meter. It reads the meter once immediately and then once after each further interval, up to a fixed number of reads in total, and stops at the first nonzero count. Next it disables the meter, then the clock gate, then the calibration enable, waits one more interval, and works out the trim code.

The trim code comes from rounded integer division by a multi-cycle restoring divider that is used twice. The first pass computes 819200 divided by the count. The second pass adds 500 to that quotient and divides by 1000. Only the low three bits are kept. If no read returns a nonzero count, the code is 4. The interval length is a parameter given in clock ticks, so a bench can use a short value.

The state machine has these states, in run order: `S_IDLE`, `S_SETTLE`, `S_FRUN_ON`, `S_WIN_LOAD`, `S_METER_ON`, `S_SAMPLE`, `S_POLL_GAP`, `S_METER_OFF`, `S_FRUN_OFF`, `S_CAL_OFF`, `S_COOL`, `S_DIV_RATE`, `S_DIV_ROUND`, `S_DONE`.

Transitions:
- `S_IDLE` goes to `S_SETTLE` on `start`.
- `S_SETTLE`, `S_POLL_GAP` and `S_COOL` each leave when the interval timer expires.
- `S_SAMPLE` goes to `S_METER_OFF` on a nonzero count or on the last allowed read. Otherwise it goes to `S_POLL_GAP`, which returns to `S_SAMPLE`.
- `S_COOL` goes to `S_DIV_RATE` if a count was captured, and to `S_DONE` if not.
- `S_DIV_RATE` goes to `S_DIV_ROUND` when the first division finishes.
- `S_DIV_ROUND` goes to `S_DONE` when the second division finishes.
- `S_DONE` returns to `S_IDLE`.
- Every other state steps to the next state in run order after one cycle.

Top module: `slew_cal_seq`

## Requirements
- R1: After an accepted start, `cal_en` rises while `frun_en` and `meter_en` are low, and exactly TICKS_PER_MS cycles pass with only `cal_en` high before `frun_en` rises.
- R2: `frun_en` rises first. `win_cnt` then holds 0x400 before `meter_en` rises, and `meter_en` rises only after `frun_en` has been high for at least one cycle.
- R3: The meter is read at most MAX_POLLS (10) times, with TICKS_PER_MS cycles between reads. A failed run keeps `meter_en` high for exactly 1 + MAX_POLLS + (MAX_POLLS-1)*TICKS_PER_MS cycles. A run that gets a nonzero count stops early.
- R4: The enables fall in the order `meter_en`, then `frun_en`, then `cal_en`, one cycle apart. At least TICKS_PER_MS+1 cycles then pass before `done`, and exactly TICKS_PER_MS+1 cycles pass on a failed run.
- R5: With a captured count C, `trim` equals bits [2:0] of ((819200/C)+500)/1000, using integer division.
- R6: If every read returns zero, `trim` is 4.
- R7: The meter counts rising edges of `meas_clk` over 0x400 `clk` cycles, but only while `frun_en` is high. It reports zero until its window completes, and it clears when disabled, so each run measures afresh.
- R8: `busy` is high from the cycle after an accepted start until `done`. `done` is a one-cycle pulse. `trim` holds its value while idle. A start pulse while busy has no effect.
- R9: Synchronous active-high `rst` returns to idle with all enables low, `busy` low, `win_cnt` zero and `trim` equal to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to calibrate; accepted only when idle |
| meas_clk | input | 1 | Raw free-running clock to be measured |
| busy | output | 1 | Calibration run in progress |
| done | output | 1 | One-cycle pulse when `trim` is updated |
| cal_en | output | 1 | Slew-rate calibration enable |
| frun_en | output | 1 | Free-running measurement clock enable |
| meter_en | output | 1 | Frequency meter enable |
| win_cnt | output | CNT_W | Programmed measurement window in reference cycles |
| trim | output | TRIM_W | Slew-rate trim code |

## Verification
On every cycle, the assertions check the rising and falling order of the three enables, that the window value is in place when the meter starts, that the meter's on-time stays within the polling bound, that `done` is a single-cycle pulse, that `trim` holds while idle, and the values left by reset. Only the bench scenarios can show the arithmetic result: the rounded trim code for several clock periods, including codes that wrap past three bits. The scenarios also cover the exact settle and cool-down lengths, the full-length timeout that gives the default code, a start ignored mid-run, and recovery after a reset during a measurement.

// File: rtl/slewcal_pkg.sv
package slewcal_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETTLE,
        S_FRUN_ON,
        S_WIN_LOAD,
        S_METER_ON,
        S_SAMPLE,
        S_POLL_GAP,
        S_METER_OFF,
        S_FRUN_OFF,
        S_CAL_OFF,
        S_COOL,
        S_DIV_RATE,
        S_DIV_ROUND,
        S_DONE
    } seq_state_t;

    // numerator: 1024 reference cycles * 25 * 32 coefficient
    localparam int unsigned SCALE_NUM  = 1024 * 25 * 32;
    localparam int unsigned ROUND_BIAS = 500;
    localparam int unsigned ROUND_DIV  = 1000;

endpackage

// File: rtl/slewcal_tick_timer.sv
module slewcal_tick_timer #(
    parameter int TICKS = 50000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic [CW-1:0] cnt;

    assign expire = run && (cnt == CW'(TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expire) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/slewcal_freq_meter.sv
module slewcal_freq_meter #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          meas_raw,
    input  logic          gate_en,
    input  logic          enable,
    input  logic [CW-1:0] window,
    output logic [CW-1:0] result
);
    logic          sync0, sync1, sync2;
    logic          rise;
    logic [CW-1:0] ref_cnt;
    logic [CW-1:0] edge_cnt;
    logic          complete;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync0 <= 1'b0;
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync0 <= meas_raw;
            sync1 <= sync0;
            sync2 <= sync1;
        end
    end

    assign rise = sync1 && !sync2 && gate_en;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            ref_cnt  <= '0;
            edge_cnt <= '0;
            complete <= 1'b0;
        end else if (!complete) begin
            edge_cnt <= edge_cnt + CW'(rise);
            if (ref_cnt == window - 1'b1) begin
                complete <= 1'b1;
            end else begin
                ref_cnt <= ref_cnt + 1'b1;
            end
        end
    end

    assign result = complete ? edge_cnt : '0;
endmodule

// File: rtl/slewcal_divider.sv
module slewcal_divider #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int SW = $clog2(W + 1);

    logic [W-1:0]  rem;
    logic [W-1:0]  quo;
    logic [W-1:0]  dvs;
    logic [SW-1:0] steps;
    logic          active;
    logic [W:0]    trial;
    logic          fits;

    assign trial = {rem, quo[W-1]};
    assign fits  = trial >= {1'b0, dvs};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem    <= '0;
            quo    <= '0;
            dvs    <= '0;
            steps  <= '0;
            active <= 1'b0;
            done   <= 1'b0;
        end else if (go) begin
            rem    <= '0;
            quo    <= dividend;
            dvs    <= divisor;
            steps  <= SW'(W);
            active <= 1'b1;
            done   <= 1'b0;
        end else if (active) begin
            if (fits) begin
                rem <= W'(trial - {1'b0, dvs});
                quo <= {quo[W-2:0], 1'b1};
            end else begin
                rem <= trial[W-1:0];
                quo <= {quo[W-2:0], 1'b0};
            end
            steps <= steps - 1'b1;
            if (steps == SW'(1)) begin
                active <= 1'b0;
                done   <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

    assign quotient = quo;
endmodule

// File: rtl/slew_cal_seq.sv
module slew_cal_seq
    import slewcal_pkg::*;
#(
    parameter int TICKS_PER_MS = 50000,
    parameter int CNT_W        = 24,
    parameter int WINDOW       = 1024,
    parameter int MAX_POLLS    = 10,
    parameter int TRIM_W       = 3,
    parameter int DEFAULT_TRIM = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              meas_clk,
    output logic              busy,
    output logic              done,
    output logic              cal_en,
    output logic              frun_en,
    output logic              meter_en,
    output logic [CNT_W-1:0]  win_cnt,
    output logic [TRIM_W-1:0] trim
);
    localparam int PW = $clog2(MAX_POLLS + 1);

    seq_state_t        state, nxt;
    logic              tmr_run, tmr_exp;
    logic [CNT_W-1:0]  meter_res;
    logic              div_go, div_done;
    logic [CNT_W-1:0]  div_a, div_b, div_q;
    logic [PW-1:0]     poll_cnt;
    logic [CNT_W-1:0]  sample_r;
    logic              got_r;
    logic [CNT_W-1:0]  win_r;
    logic [TRIM_W-1:0] trim_r;
    logic              last_poll;

    slewcal_tick_timer #(.TICKS(TICKS_PER_MS)) u_timer (
        .clk(clk), .rst(rst), .run(tmr_run), .expire(tmr_exp)
    );

    slewcal_freq_meter #(.CW(CNT_W)) u_meter (
        .clk(clk), .rst(rst), .meas_raw(meas_clk), .gate_en(frun_en),
        .enable(meter_en), .window(win_r), .result(meter_res)
    );

    slewcal_divider #(.W(CNT_W)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .dividend(div_a),
        .divisor(div_b), .done(div_done), .quotient(div_q)
    );

    assign last_poll = (poll_cnt == PW'(MAX_POLLS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:      if (start) nxt = S_SETTLE;
            S_SETTLE:    if (tmr_exp) nxt = S_FRUN_ON;
            S_FRUN_ON:   nxt = S_WIN_LOAD;
            S_WIN_LOAD:  nxt = S_METER_ON;
            S_METER_ON:  nxt = S_SAMPLE;
            S_SAMPLE:    nxt = (meter_res != '0 || last_poll) ? S_METER_OFF : S_POLL_GAP;
            S_POLL_GAP:  if (tmr_exp) nxt = S_SAMPLE;
            S_METER_OFF: nxt = S_FRUN_OFF;
            S_FRUN_OFF:  nxt = S_CAL_OFF;
            S_CAL_OFF:   nxt = S_COOL;
            S_COOL:      if (tmr_exp) nxt = got_r ? S_DIV_RATE : S_DONE;
            S_DIV_RATE:  if (div_done) nxt = S_DIV_ROUND;
            S_DIV_ROUND: if (div_done) nxt = S_DONE;
            S_DONE:      nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        cal_en   = state inside {S_SETTLE, S_FRUN_ON, S_WIN_LOAD, S_METER_ON,
                                 S_SAMPLE, S_POLL_GAP, S_METER_OFF, S_FRUN_OFF};
        frun_en  = state inside {S_FRUN_ON, S_WIN_LOAD, S_METER_ON, S_SAMPLE,
                                 S_POLL_GAP, S_METER_OFF};
        meter_en = state inside {S_METER_ON, S_SAMPLE, S_POLL_GAP};
        busy     = (state != S_IDLE);
        done     = (state == S_DONE);
        tmr_run  = state inside {S_SETTLE, S_POLL_GAP, S_COOL};
    end

    // divider operand selection: rate pass, then rounding pass
    assign div_go = (state == S_COOL && tmr_exp && got_r) ||
                    (state == S_DIV_RATE && div_done);
    assign div_a  = (state == S_COOL) ? CNT_W'(SCALE_NUM) : div_q + CNT_W'(ROUND_BIAS);
    assign div_b  = (state == S_COOL) ? sample_r : CNT_W'(ROUND_DIV);

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            poll_cnt <= '0;
            sample_r <= '0;
            got_r    <= 1'b0;
            win_r    <= '0;
            trim_r   <= TRIM_W'(DEFAULT_TRIM);
        end else begin
            if (state == S_IDLE && start) begin
                poll_cnt <= '0;
                sample_r <= '0;
                got_r    <= 1'b0;
            end
            if (state == S_WIN_LOAD) begin
                win_r <= CNT_W'(WINDOW);
            end
            if (state == S_SAMPLE) begin
                poll_cnt <= poll_cnt + 1'b1;
                if (meter_res != '0) begin
                    got_r    <= 1'b1;
                    sample_r <= meter_res;
                end
            end
            if (state == S_COOL && tmr_exp && !got_r) begin
                trim_r <= TRIM_W'(DEFAULT_TRIM);
            end
            if (state == S_DIV_ROUND && div_done) begin
                trim_r <= div_q[TRIM_W-1:0];
            end
        end
    end

    assign win_cnt = win_r;
    assign trim    = trim_r;
endmodule

// File: rtl/slewcal_checker.sv
module slewcal_checker #(
    parameter int TICKS_PER_MS = 50000,
    parameter int CNT_W        = 24,
    parameter int WINDOW       = 1024,
    parameter int MAX_POLLS    = 10,
    parameter int TRIM_W       = 3,
    parameter int DEFAULT_TRIM = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              cal_en,
    input logic              frun_en,
    input logic              meter_en,
    input logic [CNT_W-1:0]  win_cnt,
    input logic [TRIM_W-1:0] trim
);
    localparam longint LIMIT = 1 + MAX_POLLS + longint'(MAX_POLLS - 1) * TICKS_PER_MS;

    logic [47:0] meter_cnt;
    logic        past_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            meter_cnt <= '0;
            past_ok   <= 1'b1;
        end else begin
            meter_cnt <= meter_en ? meter_cnt + 1'b1 : '0;
        end
    end

    assert_cal_first_R1: assert property (@(posedge clk) disable iff (rst)
        past_ok && $rose(cal_en) |-> (!frun_en && !meter_en && busy));

    assert_frun_after_cal_R2: assert property (@(posedge clk) disable iff (rst)
        past_ok && $rose(frun_en) |-> (cal_en && $past(cal_en)));

    assert_meter_after_window_R2: assert property (@(posedge clk) disable iff (rst)
        past_ok && $rose(meter_en) |-> (frun_en && $past(frun_en) && win_cnt == CNT_W'(WINDOW)));

    assert_poll_bound_R3: assert property (@(posedge clk) disable iff (rst)
        meter_cnt <= 48'(LIMIT));

    assert_frun_off_after_meter_R4: assert property (@(posedge clk) disable iff (rst)
        past_ok && $fell(frun_en) |-> (!meter_en && cal_en));

    assert_cal_off_last_R4: assert property (@(posedge clk) disable iff (rst)
        past_ok && $fell(cal_en) |-> (!frun_en && !meter_en));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_trim_hold_R8: assert property (@(posedge clk) disable iff (rst)
        past_ok && !busy && $past(!busy) |-> $stable(trim));

    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (trim == TRIM_W'(DEFAULT_TRIM) && !busy && !cal_en && !frun_en
                 && !meter_en && win_cnt == '0));
endmodule

bind slew_cal_seq slewcal_checker #(
    .TICKS_PER_MS(TICKS_PER_MS), .CNT_W(CNT_W), .WINDOW(WINDOW),
    .MAX_POLLS(MAX_POLLS), .TRIM_W(TRIM_W), .DEFAULT_TRIM(DEFAULT_TRIM)
) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .cal_en(cal_en),
    .frun_en(frun_en), .meter_en(meter_en), .win_cnt(win_cnt), .trim(trim)
);

// File: tb/sim_slew_cal_seq.sv
module sim_slew_cal_seq;
    localparam int T      = 200;
    localparam int POLLS  = 10;
    localparam int NVEC   = 7;
    localparam int VEC_PER  [NVEC] = '{2, 3, 4, 5, 8, 12, 16};
    localparam int VEC_TRIM [NVEC] = '{2, 2, 3, 4, 6, 2, 5};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        meas = 1'b0;
    logic        busy, done, cal_en, frun_en, meter_en;
    logic [23:0] win_cnt;
    logic [2:0]  trim;

    int errors = 0;
    int checks = 0;
    int per_r  = 0;
    int ph     = 0;
    int m_settle, m_meter, m_tail, m_order;
    logic [23:0] m_win;

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (per_r == 0) begin
            meas <= 1'b0;
            ph   <= 0;
        end else begin
            ph   <= (ph + 1 >= per_r) ? 0 : ph + 1;
            meas <= (ph < per_r / 2);
        end
    end

    slew_cal_seq #(.TICKS_PER_MS(T)) u0 (
        .clk(clk), .rst(rst), .start(start), .meas_clk(meas), .busy(busy),
        .done(done), .cal_en(cal_en), .frun_en(frun_en), .meter_en(meter_en),
        .win_cnt(win_cnt), .trim(trim)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_cal(input int per, input bit poke);
        int  cyc = 0;
        int  r_cal = -1, r_frun = -1, r_met = -1, f_met = -1, f_frun = -1, f_cal = -1;
        bit  p_cal = 0, p_frun = 0, p_met = 0, fr_seen = 0, ca_fall = 0;
        per_r = per;
        m_settle = 0; m_meter = 0; m_tail = 0; m_win = '0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done) begin
            start = (poke && cyc == 40);
            if (cal_en && !p_cal)   r_cal  = cyc;
            if (frun_en && !p_frun) r_frun = cyc;
            if (meter_en && !p_met) begin r_met = cyc; m_win = win_cnt; end
            if (!meter_en && p_met) f_met  = cyc;
            if (!frun_en && p_frun) f_frun = cyc;
            if (!cal_en && p_cal) begin f_cal = cyc; ca_fall = 1; end
            if (cal_en && !frun_en && !meter_en && !fr_seen) m_settle++;
            if (frun_en) fr_seen = 1;
            if (meter_en) m_meter++;
            if (ca_fall && busy) m_tail++;
            p_cal = cal_en; p_frun = frun_en; p_met = meter_en;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        m_order = (r_cal == 0) && (r_frun > r_cal) && (r_met > r_frun) &&
                  (f_met > r_met) && (f_frun == f_met + 1) && (f_cal == f_frun + 1) &&
                  (m_win == 24'h400);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(trim == 3'd4 && !busy && !done && !cal_en && !frun_en && !meter_en && win_cnt == 0,
            "R9 reset state", int'(trim), 4);

        // vector table: measured clock period -> expected trim
        for (int i = 0; i < NVEC; i++) begin
            run_cal(VEC_PER[i], 1'b0);
            chk(trim == VEC_TRIM[i][2:0], "R5/R7 trim code", int'(trim), VEC_TRIM[i]);
            chk(m_settle == T, "R1 settle length", m_settle, T);
            chk(m_order == 1, "R2/R4 enable order and window", m_order, 1);
            chk(m_tail > T + 1, "R4 cool-down before done", m_tail, T + 2);
            chk(m_meter < 1 + POLLS + (POLLS - 1) * T, "R3 early stop", m_meter,
                1 + POLLS + (POLLS - 1) * T);
            @(negedge clk);
            chk(!done && !busy, "R8 done one cycle", int'(done), 0);
        end

        // R6 / R3 timeout: no edges on the measured clock
        run_cal(0, 1'b0);
        chk(trim == 3'd4, "R6 default trim", int'(trim), 4);
        chk(m_meter == 1 + POLLS + (POLLS - 1) * T, "R3 full poll length", m_meter,
            1 + POLLS + (POLLS - 1) * T);
        chk(m_tail == T + 1, "R4 exact cool-down", m_tail, T + 1);

        // R8 start while busy ignored, trim held afterwards
        run_cal(4, 1'b1);
        chk(trim == 3'd3 && m_settle == T && m_order == 1, "R8 start while busy", int'(trim), 3);
        repeat (30) @(negedge clk);
        chk(trim == 3'd3 && !busy && !done, "R8 trim holds idle", int'(trim), 3);

        // R9 reset during measurement
        per_r = 16;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (T + 300) @(negedge clk);
        chk(meter_en == 1'b1, "R9 mid-run setup", int'(meter_en), 1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !cal_en && !frun_en && !meter_en && trim == 3'd4 && win_cnt == 0,
            "R9 reset mid-run", int'(trim), 4);

        // recovery after reset, fresh measurement (R7)
        run_cal(2, 1'b0);
        chk(trim == 3'd2, "R7 fresh measurement after reset", int'(trim), 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule